// File: doc/BRIEF.md
# Software-Refilled Translation Cache with Pinned Entries

This block is a small, fully associative cache of page translations for a processor core. Each slot pairs a virtual page number and a process tag with a physical frame number and three access rights (read, write, execute). A lookup presents a page, the current process and an access kind. One cycle later the block answers with either the frame number or a trap together with a cause code.

The block never walks page tables itself. When a lookup misses or breaks a permission, the core takes a trap, and the handler computes the mapping and writes it in through the fill port. A filled slot may be pinned. Pinned slots are skipped by replacement and survive flushes, so time-critical mappings stay resident. On a context switch, software can drop every unpinned slot, or only the unpinned slots of one process.

Top module: `sw_tlb`

## Requirements
- R1: After reset no slot is valid, all response and fill outputs are low, and every lookup misses.
- R2: A lookup with `lk_valid` high is answered exactly one cycle later with `rsp_valid` high. It is a hit (`rsp_hit`=1, `rsp_trap`=0, `rsp_cause`=0, `rsp_pfn` = stored frame) when some valid slot has the same process tag and page number and that slot grants the requested access.
- R3: Access code `lk_acc` 0 needs the read right (`fill_perm` bit 0), 1 needs write (bit 1), 2 needs execute (bit 2), and 3 is never granted. A matching slot without the needed right answers with `rsp_trap`=1, `rsp_cause`=2, `rsp_hit`=0, `rsp_pfn`=0.
- R4: A lookup that matches no valid slot answers with `rsp_trap`=1, `rsp_cause`=1, `rsp_pfn`=0. A slot of a different process never matches.
- R5: A fill whose page and process equal those of a valid slot rewrites that slot, pinned or not. `fill_ack` is raised with `fill_slot` naming it, and the replacement pointer does not move.
- R6: Any other fill goes to the first unpinned slot at or after the replacement pointer, wrapping around. That slot is reported on `fill_slot`, and the pointer moves to the slot after it.
- R7: When every slot is pinned and no slot matches, the fill is refused. `fill_err` is high one cycle later, `fill_ack` stays low, and no slot changes.
- R8: `flush_all` invalidates every unpinned slot in one cycle. Pinned slots stay valid and keep answering.
- R9: `flush_pid_en` invalidates only unpinned slots whose tag equals `flush_pid`.
- R10: A fill presented in the same cycle as either flush is dropped. Neither `fill_ack` nor `fill_err` rises.
- R11: A lookup in the same cycle as a fill or flush is answered from the contents held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_pid | input | PID_W | Current process tag |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Answer to the lookup of the previous cycle |
| rsp_hit | output | 1 | Translation granted |
| rsp_trap | output | 1 | Miss or permission fault |
| rsp_cause | output | 2 | 0 none, 1 miss, 2 permission |
| rsp_pfn | output | PFN_W | Physical frame on a hit, else 0 |
| fill_en | input | 1 | Install request from software |
| fill_vpn | input | VPN_W | Page to install |
| fill_pid | input | PID_W | Owning process |
| fill_pfn | input | PFN_W | Frame to install |
| fill_perm | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| fill_lock | input | 1 | Pin the slot |
| fill_ack | output | 1 | Fill of the previous cycle was written |
| fill_err | output | 1 | Fill of the previous cycle was refused |
| fill_slot | output | $clog2(ENTRIES) | Slot written by the acknowledged fill |
| flush_all | input | 1 | Invalidate all unpinned slots |
| flush_pid_en | input | 1 | Invalidate unpinned slots of one process |
| flush_pid | input | PID_W | Process selected for the targeted flush |

## Verification
The bench aims at the places where a translation cache tends to go wrong.

- **Duplicate pages.** Refilling a page already present must not create a second copy. A design that did so would waste slots and advance the pointer, so later `fill_slot` values would drift from the model.
- **Replacement with pinned slots.** The round-robin search must wrap past pinned slots. A design that evicted a pinned slot would lose a mapping, and a later lookup would report a miss.
- **All slots pinned.** A design that overwrote a slot anyway, instead of raising `fill_err`, would change lookup results.
- **Flush interactions.** A flush issued alongside a fill must drop the fill, and a per-process flush must leave other processes' slots hitting.
- **Permission sweep.** Every access code, including the reserved one, is tried against every combination of rights. An inverted rights bit therefore shows up as a wrong cause code.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int PERM_W = 3;
   localparam int PERM_R = 0;
   localparam int PERM_W_BIT = 1;
   localparam int PERM_X = 2;

   typedef enum logic [1:0] {
      ACC_RD  = 2'd0,
      ACC_WR  = 2'd1,
      ACC_EX  = 2'd2,
      ACC_RSV = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      CS_NONE = 2'd0,
      CS_MISS = 2'd1,
      CS_PERM = 2'd2
   } cause_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int ENTRIES = 16,
   parameter int PID_W   = 8,
   parameter int VPN_W   = 20
) (
   input  logic [ENTRIES-1:0]            vld,
   input  logic [ENTRIES-1:0][PID_W-1:0] tags,
   input  logic [ENTRIES-1:0][VPN_W-1:0] pages,
   input  logic [PID_W-1:0]              key_pid,
   input  logic [VPN_W-1:0]              key_vpn,
   output logic [ENTRIES-1:0]            match
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld[g] && (tags[g] == key_pid) && (pages[g] == key_vpn);
   end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/tlb_rr_victim.sv
module tlb_rr_victim #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  locked,
   input  logic [IW-1:0] ptr,
   output logic          found,
   output logic [IW-1:0] idx
);
   logic [IW-1:0] cand;
   always_comb begin
      found = 1'b0;
      idx   = ptr;
      cand  = ptr;
      for (int k = N - 1; k >= 0; k--) begin
         cand = ptr + IW'(k);
         if (!locked[cand]) begin
            found = 1'b1;
            idx   = cand;
         end
      end
   end
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES    = 16,
   parameter int PID_W      = 8,
   parameter int VPN_W      = 20,
   parameter int PFN_W      = 20,
   parameter bit ALLOW_LOCK = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         lk_valid,
   input  logic [VPN_W-1:0]             lk_vpn,
   input  logic [PID_W-1:0]             lk_pid,
   input  logic [1:0]                   lk_acc,
   output logic                         rsp_valid,
   output logic                         rsp_hit,
   output logic                         rsp_trap,
   output logic [1:0]                   rsp_cause,
   output logic [PFN_W-1:0]             rsp_pfn,
   input  logic                         fill_en,
   input  logic [VPN_W-1:0]             fill_vpn,
   input  logic [PID_W-1:0]             fill_pid,
   input  logic [PFN_W-1:0]             fill_pfn,
   input  logic [2:0]                   fill_perm,
   input  logic                         fill_lock,
   output logic                         fill_ack,
   output logic                         fill_err,
   output logic [$clog2(ENTRIES)-1:0]   fill_slot,
   input  logic                         flush_all,
   input  logic                         flush_pid_en,
   input  logic [PID_W-1:0]             flush_pid
);
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("sw_tlb: ENTRIES must be a power of two and at least 2");
   end
   if (PID_W < 1 || VPN_W < 1 || PFN_W < 1) begin : g_bad_width
      $error("sw_tlb: field widths must be positive");
   end

   logic [ENTRIES-1:0]              vld_q, lck_q;
   logic [ENTRIES-1:0][PID_W-1:0]   pid_q;
   logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
   logic [ENTRIES-1:0][PFN_W-1:0]   pfn_q;
   logic [ENTRIES-1:0][PERM_W-1:0]  prm_q;
   logic [IDX_W-1:0]                ptr_q;

   // lookup path
   logic [ENTRIES-1:0] lk_match;
   logic               lk_any;
   logic [IDX_W-1:0]   lk_idx;
   logic               lk_grant;

   tlb_cam #(.ENTRIES(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W)) u_lk_cam (
      .vld(vld_q), .tags(pid_q), .pages(vpn_q),
      .key_pid(lk_pid), .key_vpn(lk_vpn), .match(lk_match));

   tlb_pick #(.N(ENTRIES), .IW(IDX_W)) u_lk_pick (
      .req(lk_match), .any(lk_any), .idx(lk_idx));

   always_comb begin
      unique case (acc_e'(lk_acc))
         ACC_RD:  lk_grant = prm_q[lk_idx][PERM_R];
         ACC_WR:  lk_grant = prm_q[lk_idx][PERM_W_BIT];
         ACC_EX:  lk_grant = prm_q[lk_idx][PERM_X];
         default: lk_grant = 1'b0;
      endcase
   end

   // fill path
   logic [ENTRIES-1:0] fl_match;
   logic               fl_any;
   logic [IDX_W-1:0]   fl_idx;
   logic               vic_found;
   logic [IDX_W-1:0]   vic_idx;
   logic               lock_in;

   tlb_cam #(.ENTRIES(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W)) u_fl_cam (
      .vld(vld_q), .tags(pid_q), .pages(vpn_q),
      .key_pid(fill_pid), .key_vpn(fill_vpn), .match(fl_match));

   tlb_pick #(.N(ENTRIES), .IW(IDX_W)) u_fl_pick (
      .req(fl_match), .any(fl_any), .idx(fl_idx));

   tlb_rr_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
      .locked(lck_q), .ptr(ptr_q), .found(vic_found), .idx(vic_idx));

   if (ALLOW_LOCK) begin : g_lock
      assign lock_in = fill_lock;
   end else begin : g_nolock
      assign lock_in = 1'b0;
   end

   logic               flush_any;
   logic [ENTRIES-1:0] clr_mask;
   logic               wr_en;
   logic [IDX_W-1:0]   wr_idx;
   logic               fill_refuse;

   assign flush_any = flush_all || flush_pid_en;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_clr
      assign clr_mask[g] = !lck_q[g] &&
                           (flush_all || (flush_pid_en && (pid_q[g] == flush_pid)));
   end

   always_comb begin
      wr_en       = 1'b0;
      wr_idx      = fl_idx;
      fill_refuse = 1'b0;
      if (fill_en && !flush_any) begin
         if (fl_any) begin
            wr_en = 1'b1;
         end else if (vic_found) begin
            wr_en  = 1'b1;
            wr_idx = vic_idx;
         end else begin
            fill_refuse = 1'b1;
         end
      end
   end

   // control state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q     <= '0;
         lck_q     <= '0;
         ptr_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_trap  <= 1'b0;
         rsp_cause <= CS_NONE;
         rsp_pfn   <= '0;
         fill_ack  <= 1'b0;
         fill_err  <= 1'b0;
         fill_slot <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && lk_any && lk_grant;
         rsp_trap  <= lk_valid && !(lk_any && lk_grant);
         rsp_pfn   <= (lk_valid && lk_any && lk_grant) ? pfn_q[lk_idx] : '0;
         if (!lk_valid)     rsp_cause <= CS_NONE;
         else if (!lk_any)  rsp_cause <= CS_MISS;
         else if (!lk_grant) rsp_cause <= CS_PERM;
         else               rsp_cause <= CS_NONE;

         vld_q    <= vld_q & ~clr_mask;
         fill_ack <= wr_en;
         fill_err <= fill_refuse;
         if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            lck_q[wr_idx] <= lock_in;
            fill_slot     <= wr_idx;
            if (!fl_any) ptr_q <= vic_idx + IDX_W'(1);
         end
      end
   end

   // slot payload, no reset needed
   always_ff @(posedge clk) begin
      if (wr_en) begin
         pid_q[wr_idx] <= fill_pid;
         vpn_q[wr_idx] <= fill_vpn;
         pfn_q[wr_idx] <= fill_pfn;
         prm_q[wr_idx] <= fill_perm;
      end
   end
endmodule

// File: rtl/sw_tlb_chk.sv
module sw_tlb_chk #(
   parameter int ENTRIES = 16,
   parameter int PFN_W   = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic               rsp_trap,
   input logic [1:0]         rsp_cause,
   input logic [PFN_W-1:0]   rsp_pfn,
   input logic               fill_en,
   input logic               fill_ack,
   input logic               fill_err,
   input logic               flush_all,
   input logic               flush_pid_en,
   input logic [ENTRIES-1:0] vld_q,
   input logic [ENTRIES-1:0] lck_q
);
   // R2: an answer only follows a request
   a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(lk_valid));

   // R2: a hit is clean
   a_r2_hit_clean: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (!rsp_trap && rsp_cause == 2'd0 && rsp_valid));

   // R4: a trap never carries a frame and always names a cause
   a_r4_trap_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_trap |-> (rsp_pfn == '0 && rsp_cause != 2'd0));

   // R7: a refusal only when every slot was pinned
   a_r7_err_all_pinned: assert property (@(posedge clk) disable iff (!rst_n)
      fill_err |-> ($past(&lck_q) && !fill_ack));

   // R5: acknowledgement only for a request
   a_r5_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      fill_ack |-> $past(fill_en));

   // R8: after a full flush only pinned slots remain valid
   a_r8_flush_leaves_pinned: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush_all) |-> ((vld_q & ~lck_q) == '0));

   // R8: pinned slots are always valid
   a_r8_pinned_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (lck_q & ~vld_q) == '0);

   // R10: a fill beside a flush is dropped
   a_r10_flush_drops_fill: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fill_en && (flush_all || flush_pid_en)) |-> (!fill_ack && !fill_err));
endmodule

bind sw_tlb sw_tlb_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_sw_tlb_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
   .rsp_hit(rsp_hit), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause), .rsp_pfn(rsp_pfn),
   .fill_en(fill_en), .fill_ack(fill_ack), .fill_err(fill_err),
   .flush_all(flush_all), .flush_pid_en(flush_pid_en),
   .vld_q(vld_q), .lck_q(lck_q));

// File: tb/sw_tlb_bench.sv
module sw_tlb_bench;
   localparam int N  = 16;
   localparam int PW = 8;
   localparam int VW = 20;
   localparam int FW = 20;
   localparam int IW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lk_valid = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic [PW-1:0] lk_pid = '0;
   logic [1:0] lk_acc = '0;
   logic rsp_valid, rsp_hit, rsp_trap;
   logic [1:0] rsp_cause;
   logic [FW-1:0] rsp_pfn;
   logic fill_en = 1'b0;
   logic [VW-1:0] fill_vpn = '0;
   logic [PW-1:0] fill_pid = '0;
   logic [FW-1:0] fill_pfn = '0;
   logic [2:0] fill_perm = '0;
   logic fill_lock = 1'b0;
   logic fill_ack, fill_err;
   logic [IW-1:0] fill_slot;
   logic flush_all = 1'b0;
   logic flush_pid_en = 1'b0;
   logic [PW-1:0] flush_pid = '0;

   always #10 clk = ~clk;

   sw_tlb u_sw_tlb (.*);

   int n_vec = 0;
   int n_bad = 0;

   // reference state
   bit            m_v[N];
   bit            m_l[N];
   int            m_pid[N];
   int            m_vpn[N];
   int            m_pfn[N];
   int            m_prm[N];
   int            m_ptr;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int m_find(input int pid, input int vpn);
      for (int i = 0; i < N; i++)
         if (m_v[i] && m_pid[i] == pid && m_vpn[i] == vpn) return i;
      return -1;
   endfunction

   function automatic int m_victim();
      for (int k = 0; k < N; k++)
         if (!m_l[(m_ptr + k) % N]) return (m_ptr + k) % N;
      return -1;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_l[i] = 0; end
      m_ptr = 0;
   endtask

   // one cycle of stimulus with any mix of lookup, fill and flushes
   task automatic step(input bit dl, input int lp, input int lv, input int la,
                       input bit df, input int fp, input int fv, input int ff,
                       input int fr, input bit fk, input bit fa, input bit fpe,
                       input int fpp);
      int  e_hit, e_cause, e_pfn, m, e_ack, e_err, e_slot;
      string ltag, ftag;
      @(negedge clk);
      lk_valid = dl; lk_pid = PW'(lp); lk_vpn = VW'(lv); lk_acc = 2'(la);
      fill_en = df; fill_pid = PW'(fp); fill_vpn = VW'(fv); fill_pfn = FW'(ff);
      fill_perm = 3'(fr); fill_lock = fk;
      flush_all = fa; flush_pid_en = fpe; flush_pid = PW'(fpp);
      // R11: lookup result comes from contents before this cycle
      m = m_find(lp, lv);
      if (m < 0) begin
         e_hit = 0; e_cause = 1; e_pfn = 0; ltag = "R4";
      end else if (la < 3 && m_prm[m][la]) begin
         e_hit = 1; e_cause = 0; e_pfn = m_pfn[m]; ltag = "R2";
      end else begin
         e_hit = 0; e_cause = 2; e_pfn = 0; ltag = "R3";
      end
      e_ack = 0; e_err = 0; e_slot = 0; ftag = "R10";
      if (df && !(fa || fpe)) begin
         m = m_find(fp, fv);
         if (m >= 0) begin
            e_ack = 1; e_slot = m; ftag = "R5";
         end else begin
            m = m_victim();
            if (m >= 0) begin
               e_ack = 1; e_slot = m; ftag = "R6"; m_ptr = (m + 1) % N;
            end else begin
               e_err = 1; ftag = "R7";
            end
         end
      end
      // R8 R9: flush model
      for (int i = 0; i < N; i++)
         if (!m_l[i] && (fa || (fpe && m_pid[i] == fpp))) m_v[i] = 0;
      if (e_ack) begin
         m_v[e_slot] = 1; m_l[e_slot] = fk; m_pid[e_slot] = fp;
         m_vpn[e_slot] = fv; m_pfn[e_slot] = ff; m_prm[e_slot] = fr;
      end
      @(negedge clk);
      if (dl)
         check(rsp_valid && rsp_hit == e_hit[0] && rsp_trap == !e_hit[0] &&
               rsp_cause == 2'(e_cause) && rsp_pfn == FW'(e_pfn), ltag,
               {rsp_valid, rsp_hit, rsp_trap, rsp_cause, rsp_pfn},
               {1'b1, e_hit[0], !e_hit[0], 2'(e_cause), FW'(e_pfn)});
      if (df)
         check(fill_ack == e_ack[0] && fill_err == e_err[0] &&
               (!e_ack[0] || fill_slot == IW'(e_slot)), ftag,
               {fill_ack, fill_err, fill_slot}, {e_ack[0], e_err[0], IW'(e_slot)});
      lk_valid = 1'b0; fill_en = 1'b0; flush_all = 1'b0; flush_pid_en = 1'b0;
   endtask

   task automatic look(input int lp, input int lv, input int la);
      step(1, lp, lv, la, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic fill(input int fp, input int fv, input int ff, input int fr, input bit fk);
      step(0, 0, 0, 0, 1, fp, fv, ff, fr, fk, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   logic [15:0] lfsr = 16'hACE1;
   function automatic logic [15:0] nxt(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   initial begin : main
      logic [15:0] a, b;
      do_reset();
      // R1: reset state
      @(negedge clk);
      check({rsp_valid, rsp_hit, rsp_trap, fill_ack, fill_err} == 5'b0, "R1",
            {rsp_valid, rsp_hit, rsp_trap, fill_ack, fill_err}, 0);
      for (int v = 0; v < 4; v++) look(0, v, 0);

      // R6: fill every slot in order, rights sweep over all eight codes
      for (int i = 0; i < N; i++) fill(5, 3 * i + 1, 100 + 7 * i, i % 8, 0);
      // R2 R3: every access code against every rights combination
      for (int i = 0; i < N; i++)
         for (int acc = 0; acc < 4; acc++) look(5, 3 * i + 1, acc);
      // R4: other process never matches
      for (int i = 0; i < N; i += 3) look(6, 3 * i + 1, 0);
      // R6 wrap, R5 in-place overwrite
      fill(5, 500, 77, 7, 0);
      fill(5, 3 * 5 + 1, 999, 7, 0);
      look(5, 16, 1);
      fill(5, 501, 78, 7, 0);
      // R11: lookup and overwrite of the same page in one cycle
      step(1, 5, 501, 0, 1, 5, 501, 55, 1, 0, 0, 0, 0);
      look(5, 501, 0);

      // pseudo-random mix over a small page and process space
      for (int t = 0; t < 1500; t++) begin
         lfsr = nxt(lfsr); a = lfsr;
         lfsr = nxt(lfsr); b = lfsr;
         case (a[3:0])
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4:
               look(b[1:0], b[6:2] % 24, b[8:7]);
            4'd5, 4'd6, 4'd7, 4'd8:
               fill(b[1:0], b[6:2] % 24, b[15:9], a[6:4], a[15:12] == 4'd0);
            4'd9, 4'd10:
               step(1, b[1:0], b[6:2] % 24, b[8:7], 1, a[5:4], a[10:6] % 24,
                    b[15:9], a[13:11], 1'b0, 0, 0, 0);
            4'd11:
               step(1, b[1:0], b[6:2] % 24, b[8:7], 0, 0, 0, 0, 0, 0, 0, 1, a[5:4]);
            4'd12:
               step(0, 0, 0, 0, 1, b[1:0], b[6:2] % 24, 1, 7, 0, 0, 1, a[5:4]);
            4'd13:
               if (a[7:4] == 4'd0) step(1, b[1:0], b[6:2] % 24, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
               else look(b[1:0], b[6:2] % 24, b[8:7]);
            default:
               for (int v = 0; v < 3; v++) look(a[5:4], (b[4:0] + v) % 24, 0);
         endcase
      end

      // R7 R8: pin every slot, then refuse, then flush keeps them
      do_reset();
      for (int i = 0; i < N; i++) fill(2, 40 + i, 300 + i, 1, 1);
      fill(2, 99, 1, 1, 0);
      fill(3, 40, 1, 1, 0);
      fill(2, 45, 345, 3, 1);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
      for (int i = 0; i < N; i++) look(2, 40 + i, 0);
      look(2, 99, 0);
      // R9 R10: unpin one slot, targeted flush, fill beside a flush
      fill(2, 41, 7, 1, 0);
      step(1, 2, 41, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3);
      step(1, 2, 41, 0, 1, 2, 60, 1, 1, 0, 0, 1, 2);
      look(2, 41, 0);
      fill(2, 60, 61, 1, 0);
      look(2, 60, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule